// File: doc/BRIEF.md
# Three-wire serial control slave

This block is the device end of a three-wire serial control bus: a bus clock, a mode line and a shared data line. The controller first sends a selection byte with the mode line low. That byte carries a 6-bit device address and two transfer-type bits. It then raises the mode line and sends or collects bytes. Every byte travels least significant bit first. A write burst names a 7-bit register and supplies a 16-bit value, high byte first. A read is done in two steps. A prepare step names the register. A later read burst returns a status byte holding that register number and a validity flag, followed by the register value.

All bus lines are brought into the system clock domain through a synchronizer. Edges are detected there, so the bus clock must be much slower than `clk`. The register file drives a flat output word that the surrounding logic consumes. The interface sleeps after reset until it has seen one bus clock pulse, and that pulse is not taken as a data bit.

Top module: `tws_ctl_slave`

## Requirements
- R1: After reset no bus bit is accepted until one rising edge of the bus clock has been seen; that first edge is not a data bit, so a transfer begun while asleep changes no register and never enables the data driver.
- R2: Data bits are taken at rising edges of the bus clock, least significant bit first, eight to a byte; any change of the mode line restarts byte framing at bit 0.
- R3: A selection byte (mode low) is accepted only when its bits 7..2 equal the DEV_ADDR parameter; on a mismatch the following data-mode bursts write nothing and the data driver stays off.
- R4: Transfer-type bits [1:0] of the selection byte: 2'b10 selects write/prepare, 2'b11 selects read, and any value with bit 1 = 0 makes the slave ignore the following data-mode bursts.
- R5: After a 2'b10 selection, a data burst whose first byte has bit 0 = 0 names a register in bits 7..1; the next two bytes are the high and low halves of the new value, written when the low byte completes, and any further bytes in that burst are ignored.
- R6: A write to a register number of NREG or above changes no register.
- R7: After a 2'b10 selection, a first byte with bit 0 = 1 records bits 7..1 as the prepared register and changes no register.
- R8: After a 2'b11 selection, raising the mode line starts a 24-bit reply, LSB first per byte: a status byte {prepared register, bit0 = 0 when valid}, then the value's high byte, then its low byte; each bit is changed only after a falling bus clock edge and the output enable is high for exactly those bits.
- R9: If no prepare has occurred since reset, or the prepared register is NREG or above, the status byte has bit 0 = 1 and both data bytes are zero; with no prepare the register field reads 0.
- R10: The output enable drops whenever the mode line goes low.
- R11: Reset clears every register to zero and turns the data driver off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_clk_i | input | 1 | Bus clock from the controller |
| sc_mode_i | input | 1 | Bus mode line: low = selection, high = data |
| sc_dat_i | input | 1 | Bus data seen at the pad |
| sc_dat_o | output | 1 | Bus data driven by the slave during a read |
| sc_dat_oe | output | 1 | Output enable for sc_dat_o |
| regs_o | output | NREG*16 | All registers, register i in bits [16*i+15:16*i] |

## Verification
The bench builds the slave with DEV_ADDR = 6'h2C and NREG = 6. This puts register 6 inside the 7-bit address field but outside the implemented file, so the invalid-address paths for writes and reads can be reached with a single step. It keeps SYNC_STAGES at 2 and holds each bus clock phase for 8 system cycles. That leaves room for the synchronizer and edge-detect latency before each read bit is sampled. A second device address, one bit away from DEV_ADDR, is used to exercise the mismatch path.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int unsigned REG_W     = 16;
  localparam int unsigned RADDR_W   = 7;
  localparam int unsigned REPLY_LEN = 24;

  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2
  } xfer_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WSEL = 2'd1,
    CS_READ = 2'd2
  } ctl_st_e;

  // transfer type from bits [1:0] of the selection byte
  function automatic xfer_e type_decode(input logic [1:0] t);
    if (!t[1])     return XF_NONE;
    else if (t[0]) return XF_READ;
    else           return XF_WRITE;
  endfunction

  function automatic logic reg_in_range(input logic [RADDR_W-1:0] a,
                                        input int unsigned n);
    return (32'(a) < n);
  endfunction

  // reply bits in shift order: status byte, high byte, low byte
  function automatic logic [REPLY_LEN-1:0] reply_word(
      input logic [RADDR_W-1:0] a, input logic ok, input logic [REG_W-1:0] d);
    logic [REG_W-1:0] v;
    v = ok ? d : '0;
    return {v[7:0], v[15:8], a, ~ok};
  endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_framer.sv
module tws_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_bit,
  input  logic       din,
  input  logic       restart,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic [2:0] bit_cnt
);
  logic [7:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (restart) begin
        bit_cnt <= '0;
      end else if (take_bit) begin
        sr      <= {din, sr[7:1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= {din, sr[7:1]};
        end
      end
    end
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR = 6'h2C,
  parameter int unsigned NREG     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic               mode_edge,
  input  logic               byte_done,
  input  logic [7:0]         byte_val,
  output logic               wr_commit,
  output logic [RADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]   wr_data,
  output logic [RADDR_W-1:0] prep_addr,
  output logic               prep_ok,
  output logic               rd_armed
);
  ctl_st_e    st;
  logic [1:0] idx;
  logic       wr_pend;
  logic       prep_seen;
  logic [7:0] wr_hi;
  logic       sel_byte, dat_byte;

  assign sel_byte  = byte_done & ~mode;
  assign dat_byte  = byte_done & mode & (st == CS_WSEL);
  assign wr_data   = {wr_hi, byte_val};
  assign wr_commit = dat_byte & (idx == 2'd2) & wr_pend & reg_in_range(wr_addr, NREG);
  assign prep_ok   = prep_seen & reg_in_range(prep_addr, NREG);
  assign rd_armed  = (st == CS_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= CS_IDLE;
      idx       <= '0;
      wr_pend   <= 1'b0;
      prep_seen <= 1'b0;
      wr_hi     <= '0;
      wr_addr   <= '0;
      prep_addr <= '0;
    end else begin
      if (mode_edge) idx <= '0;
      else if (byte_done && mode && idx != 2'd3) idx <= idx + 2'd1;

      if (sel_byte) begin
        wr_pend <= 1'b0;
        if (byte_val[7:2] != DEV_ADDR) st <= CS_IDLE;
        else begin
          unique case (type_decode(byte_val[1:0]))
            XF_WRITE: st <= CS_WSEL;
            XF_READ:  st <= CS_READ;
            default:  st <= CS_IDLE;
          endcase
        end
      end

      if (dat_byte) begin
        unique case (idx)
          2'd0: begin
            if (byte_val[0]) begin
              prep_addr <= byte_val[7:1];
              prep_seen <= 1'b1;
              wr_pend   <= 1'b0;
            end else begin
              wr_addr <= byte_val[7:1];
              wr_pend <= 1'b1;
            end
          end
          2'd1:    if (wr_pend) wr_hi <= byte_val;
          2'd2:    wr_pend <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tws_tx.sv
module tws_tx #(
  parameter int unsigned LEN = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           stop,
  input  logic [LEN-1:0] frame,
  input  logic           bit_rise,
  input  logic           bit_fall,
  output logic           dout,
  output logic           oe
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [LEN-1:0] sr;
  logic [CW-1:0]  left;
  logic           pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
      pend <= 1'b0;
      oe   <= 1'b0;
    end else if (stop) begin
      oe   <= 1'b0;
      pend <= 1'b0;
    end else if (start) begin
      sr   <= frame;
      left <= CW'(LEN);
      pend <= 1'b0;
      oe   <= 1'b1;
    end else if (oe) begin
      if (bit_rise && left != '0) begin
        left <= left - CW'(1);
        pend <= 1'b1;
      end else if (bit_fall && pend) begin
        pend <= 1'b0;
        sr   <= sr >> 1;
        if (left == '0) oe <= 1'b0;
      end
    end
  end

  assign dout = oe & sr[0];
endmodule

// File: rtl/tws_regfile.sv
module tws_regfile
  import tws_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RADDR_W-1:0] waddr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [RADDR_W-1:0] raddr,
  output logic [REG_W-1:0]   rdata,
  output logic [NREG*REG_W-1:0] flat
);
  for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we && waddr == RADDR_W'(g)) q <= wdata;
    end
    assign flat[g*REG_W +: REG_W] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < int'(NREG); i++)
      if (raddr == RADDR_W'(i)) rdata = flat[i*REG_W +: REG_W];
  end
endmodule

// File: rtl/tws_ctl_slave.sv
module tws_ctl_slave
  import tws_pkg::*;
#(
  parameter logic [5:0]  DEV_ADDR    = 6'h2C,
  parameter int unsigned NREG        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sc_clk_i,
  input  logic                  sc_mode_i,
  input  logic                  sc_dat_i,
  output logic                  sc_dat_o,
  output logic                  sc_dat_oe,
  output logic [NREG*REG_W-1:0] regs_o
);
  // synchronized lines and named events
  logic s_clk, s_mode, s_dat;
  logic clk_q, mode_q, awake;
  logic bit_rise, bit_fall, mode_edge, take_bit;
  logic byte_done;
  logic [7:0] byte_val;
  logic [2:0] bit_cnt;
  logic wr_commit, prep_ok, rd_armed;
  logic [RADDR_W-1:0] wr_addr, prep_addr;
  logic [REG_W-1:0] wr_data, rd_data;
  logic tx_start, tx_stop;

  tws_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sc_clk_i, sc_mode_i, sc_dat_i}),
    .q({s_clk, s_mode, s_dat})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      mode_q <= 1'b0;
      awake  <= 1'b0;
    end else begin
      clk_q  <= s_clk;
      mode_q <= s_mode;
      if (bit_rise) awake <= 1'b1;
    end
  end

  assign bit_rise  = s_clk & ~clk_q;
  assign bit_fall  = ~s_clk & clk_q;
  assign mode_edge = s_mode ^ mode_q;
  assign take_bit  = bit_rise & awake;
  assign tx_start  = mode_edge & s_mode & rd_armed;
  assign tx_stop   = mode_edge & ~s_mode;

  tws_framer u_framer (
    .clk(clk), .rst_n(rst_n), .take_bit(take_bit), .din(s_dat),
    .restart(mode_edge), .byte_done(byte_done), .byte_val(byte_val),
    .bit_cnt(bit_cnt)
  );

  tws_ctrl #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(s_mode), .mode_edge(mode_edge),
    .byte_done(byte_done), .byte_val(byte_val), .wr_commit(wr_commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .prep_addr(prep_addr),
    .prep_ok(prep_ok), .rd_armed(rd_armed)
  );

  tws_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(wr_addr),
    .wdata(wr_data), .raddr(prep_addr), .rdata(rd_data), .flat(regs_o)
  );

  tws_tx #(.LEN(REPLY_LEN)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .stop(tx_stop),
    .frame(reply_word(prep_addr, prep_ok, rd_data)),
    .bit_rise(bit_rise), .bit_fall(bit_fall),
    .dout(sc_dat_o), .oe(sc_dat_oe)
  );
endmodule

// File: rtl/tws_ctl_slave_chk.sv
module tws_ctl_slave_chk #(
  parameter int unsigned RW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_mode,
  input logic          mode_edge,
  input logic          awake,
  input logic          byte_done,
  input logic [2:0]    bit_cnt,
  input logic          wr_commit,
  input logic          sc_dat_oe,
  input logic [RW-1:0] regs_o
);
  // R1: nothing is counted or driven while asleep
  p_asleep_no_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> (bit_cnt == 3'd0 && !sc_dat_oe));

  // R2: a mode change restarts framing
  p_framing_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_edge |=> (bit_cnt == 3'd0));

  // R2: a completed byte is a single-cycle event
  p_byte_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  // R6: registers move only on an accepted write
  p_regs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(regs_o));

  // R8: the driver is only switched on in data mode
  p_drive_data_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_dat_oe) |-> s_mode);

  // R10: mode low turns the driver off
  p_release_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_edge && !s_mode) |=> !sc_dat_oe);
endmodule

bind tws_ctl_slave tws_ctl_slave_chk #(.RW(NREG*16)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_mode(s_mode), .mode_edge(mode_edge),
  .awake(awake), .byte_done(byte_done), .bit_cnt(bit_cnt),
  .wr_commit(wr_commit), .sc_dat_oe(sc_dat_oe), .regs_o(regs_o)
);

// File: tb/sim_tws_ctl_slave.sv
`timescale 1ns/1ps
module sim_tws_ctl_slave;
  localparam logic [5:0] DEV  = 6'h2C;
  localparam logic [5:0] BAD  = 6'h2D;
  localparam int         NREG = 6;
  localparam int         H    = 8;

  localparam logic [3:0] OP_WR = 4'd0, OP_PREP = 4'd1, OP_RD = 4'd2,
    OP_WR_BADDEV = 4'd3, OP_WR_T00 = 4'd4, OP_WR_EXTRA = 4'd5, OP_RD_BADDEV = 4'd6;
  localparam int NV = 19;
  // {op, register, data (write value or expected read value), expected status byte}
  localparam logic [35:0] VEC [NV] = '{
    {OP_WR,        8'd0, 16'h1234, 8'h00},
    {OP_WR,        8'd5, 16'hA5C3, 8'h00},
    {OP_WR,        8'd6, 16'hFFFF, 8'h00},  // R6 out of range
    {OP_PREP,      8'd5, 16'h0000, 8'h00},  // R7
    {OP_RD,        8'd0, 16'hA5C3, 8'h0A},
    {OP_PREP,      8'd0, 16'h0000, 8'h00},
    {OP_RD,        8'd0, 16'h1234, 8'h00},
    {OP_PREP,      8'd6, 16'h0000, 8'h00},
    {OP_RD,        8'd0, 16'h0000, 8'h0D},  // R9 invalid register
    {OP_PREP,      8'd1, 16'h0000, 8'h00},
    {OP_RD,        8'd0, 16'h0000, 8'h02},  // R1 asleep write left reg 1 at zero
    {OP_WR_BADDEV, 8'd0, 16'hDEAD, 8'h00},  // R3
    {OP_WR_T00,    8'd0, 16'h5555, 8'h00},  // R4
    {OP_WR_EXTRA,  8'd2, 16'h0F0E, 8'h00},  // R5 trailing byte
    {OP_PREP,      8'd2, 16'h0000, 8'h00},
    {OP_RD,        8'd0, 16'h0F0E, 8'h04},
    {OP_RD_BADDEV, 8'd0, 16'h0000, 8'h00},  // R3 no drive
    {OP_PREP,      8'd0, 16'h0000, 8'h00},
    {OP_RD,        8'd0, 16'h1234, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sc_clk = 1'b0, sc_mode = 1'b0, sc_dat = 1'b0;
  logic sc_dat_o, sc_dat_oe;
  logic [NREG*16-1:0] regs;
  logic [15:0] mdl [NREG];
  int checks = 0, fails = 0;
  logic oe_seen = 1'b0;

  always #5 clk = ~clk;

  tws_ctl_slave #(.DEV_ADDR(DEV), .NREG(NREG), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sc_clk_i(sc_clk), .sc_mode_i(sc_mode),
    .sc_dat_i(sc_dat), .sc_dat_o(sc_dat_o), .sc_dat_oe(sc_dat_oe), .regs_o(regs)
  );

  always @(negedge clk) if (sc_dat_oe) oe_seen <= 1'b1;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*16-1:0] model_flat();
    logic [NREG*16-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*16 +: 16] = mdl[i];
    return f;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sc_dat = b;
    wait_cyc(H); sc_clk = 1'b1;
    wait_cyc(H); sc_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) pulse_bit(v[i]);
  endtask

  task automatic set_mode(input logic m);
    sc_mode = m;
    wait_cyc(H);
  endtask

  task automatic select(input logic [5:0] dev, input logic [1:0] t);
    set_mode(1'b0);
    send_byte({dev, t});
  endtask

  task automatic do_write(input logic [5:0] dev, input logic [1:0] t,
                          input logic [6:0] a, input logic [15:0] d, input bit extra);
    select(dev, t);
    set_mode(1'b1);
    send_byte({a, 1'b0});
    send_byte(d[15:8]);
    send_byte(d[7:0]);
    if (extra) send_byte(8'h77);
    set_mode(1'b0);
  endtask

  task automatic do_prep(input logic [6:0] a);
    select(DEV, 2'b10);
    set_mode(1'b1);
    send_byte({a, 1'b1});
    set_mode(1'b0);
  endtask

  task automatic do_read(input logic [5:0] dev, output logic [23:0] got,
                         output logic oe_all, output logic oe_any);
    select(dev, 2'b11);
    set_mode(1'b1);
    oe_all = 1'b1; oe_any = 1'b0; got = '0;
    for (int i = 0; i < 24; i++) begin
      wait_cyc(H);
      got[i] = sc_dat_o;
      oe_all &= sc_dat_oe;
      oe_any |= sc_dat_oe;
      sc_clk = 1'b1;
      wait_cyc(H);
      sc_clk = 1'b0;
    end
    set_mode(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [23:0] got;
    logic oe_all, oe_any;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    wait_cyc(4);
    // R11 reset state
    check("R11 regs at reset", 64'(regs), 64'(0));
    check("R11 driver off at reset", 64'(sc_dat_oe), 64'(0));
    rst_n = 1'b1;
    wait_cyc(4);

    // R1: first transfer after reset arrives asleep and is misframed
    do_write(DEV, 2'b10, 7'd1, 16'hBEEF, 1'b0);
    check("R1 asleep write ignored", 64'(regs), 64'(0));

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  op;
      logic [6:0]  ra;
      logic [15:0] dv;
      logic [7:0]  eb;
      {op, ra, dv, eb} = {VEC[v][35:32], VEC[v][30:24], VEC[v][23:8], VEC[v][7:0]};
      case (op)
        OP_WR, OP_WR_EXTRA: begin
          do_write(DEV, 2'b10, ra, dv, op == OP_WR_EXTRA);
          if (ra < NREG) mdl[ra] = dv;
          check(op == OP_WR_EXTRA ? "R5 write with trailing byte" :
                (ra < NREG ? "R5 write" : "R6 out-of-range write"),
                64'(regs), 64'(model_flat()));
        end
        OP_WR_BADDEV: begin
          do_write(BAD, 2'b10, ra, dv, 1'b0);
          check("R3 other device write", 64'(regs), 64'(model_flat()));
        end
        OP_WR_T00: begin
          do_write(DEV, 2'b00, ra, dv, 1'b0);
          check("R4 type 00 write", 64'(regs), 64'(model_flat()));
        end
        OP_PREP: begin
          do_prep(ra);
          check("R7 prepare leaves registers", 64'(regs), 64'(model_flat()));
        end
        OP_RD: begin
          do_read(DEV, got, oe_all, oe_any);
          check(eb[0] ? "R9 invalid read frame" : "R8 read frame",
                64'(got), 64'({dv[7:0], dv[15:8], eb}));
          check("R8 enable over reply", 64'(oe_all), 64'(1));
          check("R10 enable after mode low", 64'(sc_dat_oe), 64'(0));
        end
        default: begin
          do_read(BAD, got, oe_all, oe_any);
          check("R3 other device read not driven", 64'(oe_any), 64'(0));
        end
      endcase
    end

    // R2: stray bits then a mode toggle must not disturb the next byte
    set_mode(1'b0);
    for (int i = 0; i < 5; i++) pulse_bit(1'b1);
    set_mode(1'b1);
    set_mode(1'b0);
    do_write(DEV, 2'b10, 7'd3, 16'h3C5A, 1'b0);
    mdl[3] = 16'h3C5A;
    check("R2 framing restart", 64'(regs), 64'(model_flat()));

    // R9: fresh reset, read without any prepare
    rst_n = 1'b0;
    wait_cyc(4);
    check("R11 regs cleared by reset", 64'(regs), 64'(0));
    rst_n = 1'b1;
    wait_cyc(4);
    pulse_bit(1'b0);
    do_read(DEV, got, oe_all, oe_any);
    check("R9 read with no prepare", 64'(got), 64'(24'h000001));

    summary();
    $finish;
  end
endmodule